// File: doc/BRIEF.md
# Lockstep Replay Gate

This block sits on the trailing (slave) side of a two-node lockstep pair. The leading node copies every external event its processor sees, such as an interrupt, a cache-line fill or a coherence request. It stamps the copy with the cycle on which it saw the event and sends it across. The gate stores these records and holds each one back. It releases a record to the trailing processor's input port in the single cycle whose local time equals the stamp. Both processors therefore see the same event on the same cycle of their own execution.

Local time is a free-running cycle count minus a configured lag. The lag is chosen to exceed the worst-case transit time of a record. When a record arrives, the gate measures its slack: the stamp minus local time. The last measured slack drives two clock-skew requests. If slack is too small, the trailing clock should be slowed. If slack is too large, the leading clock should be slowed. A record that arrives with no slack left sets a sticky error flag. It is still handed on at the first opportunity.

Top module: `lockstep_replay_gate`

## Requirements
- R1: While reset is held and in the first cycle after it, `local_time` equals 0 minus `lag_cfg` modulo 2^TS_W. In that window `out_valid`, `slack_valid`, `late_err`, `retard_slave`, `retard_master` and `in_full` are all 0.
- R2: `local_time` advances by exactly one per clock modulo 2^TS_W while `lag_cfg` is held.
- R3: An accepted record whose slack is at least 1 is presented for exactly one cycle. That cycle is the one in which `local_time` equals its stamp, with `out_ts` and `out_data` carrying the stored stamp and payload, and never earlier.
- R4: Records leave in arrival order, at most one per cycle. Records with consecutive stamps leave on consecutive cycles.
- R5: Slack is (stamp minus `local_time`) modulo 2^TS_W, read as a two's-complement number. It is taken in the cycle a record is accepted. On the next cycle it appears on `slack_val` together with a one-cycle `slack_valid` pulse.
- R6: `retard_slave` is 1 exactly when the last reported slack is below `slack_lo` (signed). It holds until the next accepted record.
- R7: `retard_master` is 1 exactly when the last reported slack is above `slack_hi` (signed). It holds until the next accepted record.
- R8: An accepted record with slack of 0 or less sets `late_err`, which stays at 1 until reset. If nothing is queued ahead of the record, it is presented in the cycle after acceptance.
- R9: Stamps and local time are compared modulo 2^TS_W. A record whose stamp lies past the counter wrap is delivered on the correct cycle after the wrap.
- R10: `in_full` is 1 while DEPTH records are held. A record offered while `in_full` is 1 is dropped: it produces no `slack_valid` pulse, does not change the slack or request outputs, and is never presented.
- R11: With `slack_lo` not above `slack_hi`, the two retard requests are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lag_cfg | input | TS_W | Lag subtracted from the cycle count to form local time |
| slack_lo | input | TS_W | Signed slack floor; below it the trailing clock is to be slowed |
| slack_hi | input | TS_W | Signed slack ceiling; above it the leading clock is to be slowed |
| in_valid | input | 1 | A forwarded record is offered this cycle |
| in_ts | input | TS_W | Delivery stamp of the offered record |
| in_data | input | PAY_W | Copied event payload |
| in_full | output | 1 | Queue holds DEPTH records; offers are dropped |
| out_valid | output | 1 | A record is presented to the processor this cycle |
| out_ts | output | TS_W | Stamp of the presented record |
| out_data | output | PAY_W | Payload of the presented record |
| local_time | output | TS_W | Delayed local time reference |
| slack_valid | output | 1 | One-cycle pulse: a new slack value is shown |
| slack_val | output | TS_W | Slack of the last accepted record, two's complement |
| retard_slave | output | 1 | Request to slow the trailing clock |
| retard_master | output | 1 | Request to slow the leading clock |
| late_err | output | 1 | Sticky: some record arrived with no slack left |

## Verification
The properties take for granted that `lag_cfg` stays constant between resets. They also assume that accepted stamps strictly increase in arrival order, that every slack magnitude stays under half the stamp range, and that `slack_lo` does not exceed `slack_hi`. The stimulus derives every stamp from the bench's own cycle count plus a chosen slack between -3 and 20. It sends bursts only with rising stamps, keeps the thresholds fixed at 2 and 8, and changes the lag only while reset is held. The single out-of-order offer is made while the queue is full, so it is dropped.

// File: rtl/lockstep_replay_gate.sv
module lockstep_replay_gate #(
  parameter int TS_W  = 16,
  parameter int PAY_W = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  lag_cfg,
  input  logic [TS_W-1:0]  slack_lo,
  input  logic [TS_W-1:0]  slack_hi,
  input  logic             in_valid,
  input  logic [TS_W-1:0]  in_ts,
  input  logic [PAY_W-1:0] in_data,
  output logic             in_full,
  output logic             out_valid,
  output logic [TS_W-1:0]  out_ts,
  output logic [PAY_W-1:0] out_data,
  output logic [TS_W-1:0]  local_time,
  output logic             slack_valid,
  output logic [TS_W-1:0]  slack_val,
  output logic             retard_slave,
  output logic             retard_master,
  output logic             late_err
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [TS_W-1:0]  cyc_q;
  logic [TS_W-1:0]  ts_mem  [DEPTH];
  logic [PAY_W-1:0] pay_mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  logic signed [TS_W-1:0] arr_slack;
  logic signed [TS_W-1:0] head_gap;
  logic accept, pop;

  assign local_time = cyc_q - lag_cfg;
  assign in_full    = (count == CNT_W'(DEPTH));
  assign accept     = in_valid && !in_full;
  assign arr_slack  = in_ts - local_time;

  assign out_ts    = ts_mem[rd_ptr];
  assign out_data  = pay_mem[rd_ptr];
  assign head_gap  = out_ts - local_time;
  assign out_valid = (count != '0) && (head_gap <= 0);
  assign pop       = out_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      ts_mem[wr_ptr]  <= in_ts;
      pay_mem[wr_ptr] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)    rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (accept && !pop)      count <= count + 1'b1;
      else if (pop && !accept) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slack_valid   <= 1'b0;
      slack_val     <= '0;
      retard_slave  <= 1'b0;
      retard_master <= 1'b0;
      late_err      <= 1'b0;
    end else begin
      slack_valid <= accept;
      if (accept) begin
        slack_val     <= arr_slack;
        retard_slave  <= arr_slack < $signed(slack_lo);
        retard_master <= arr_slack > $signed(slack_hi);
        if (arr_slack <= 0) late_err <= 1'b1;
      end
    end
  end

endmodule

module lockstep_replay_gate_chk #(
  parameter int TS_W  = 16,
  parameter int CNT_W = 4,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TS_W-1:0]  slack_lo,
  input logic [TS_W-1:0]  slack_hi,
  input logic             in_valid,
  input logic             in_full,
  input logic             out_valid,
  input logic [TS_W-1:0]  out_ts,
  input logic [TS_W-1:0]  local_time,
  input logic             slack_valid,
  input logic             retard_slave,
  input logic             retard_master,
  input logic             late_err,
  input logic [CNT_W-1:0] count
);

  assert_time_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> local_time == TS_W'($past(local_time) + 1'b1));

  assert_exact_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !late_err) |-> out_ts == local_time);

  assert_slack_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slack_valid |-> $past(in_valid && !in_full));

  assert_late_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(late_err) |-> late_err);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_drop_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_full) |=> count <= $past(count));

  assert_no_conflict_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(slack_lo) <= $signed(slack_hi)) |-> !(retard_slave && retard_master));

endmodule

bind lockstep_replay_gate lockstep_replay_gate_chk #(
  .TS_W(TS_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .slack_lo(slack_lo), .slack_hi(slack_hi),
  .in_valid(in_valid), .in_full(in_full), .out_valid(out_valid),
  .out_ts(out_ts), .local_time(local_time), .slack_valid(slack_valid),
  .retard_slave(retard_slave), .retard_master(retard_master),
  .late_err(late_err), .count(count)
);

// File: tb/lockstep_replay_gate_tb_top.sv
module lockstep_replay_gate_tb_top;
  localparam int TS_W = 8, PAY_W = 8, DEPTH = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [TS_W-1:0] lag_cfg = '0, slack_lo = 8'd2, slack_hi = 8'd8;
  logic in_valid = 1'b0;
  logic [TS_W-1:0] in_ts = '0;
  logic [PAY_W-1:0] in_data = '0;
  logic in_full, out_valid, slack_valid, retard_slave, retard_master, late_err;
  logic [TS_W-1:0] out_ts, local_time, slack_val;
  logic [PAY_W-1:0] out_data;

  lockstep_replay_gate #(.TS_W(TS_W), .PAY_W(PAY_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .lag_cfg(lag_cfg), .slack_lo(slack_lo),
    .slack_hi(slack_hi), .in_valid(in_valid), .in_ts(in_ts), .in_data(in_data),
    .in_full(in_full), .out_valid(out_valid), .out_ts(out_ts), .out_data(out_data),
    .local_time(local_time), .slack_valid(slack_valid), .slack_val(slack_val),
    .retard_slave(retard_slave), .retard_master(retard_master), .late_err(late_err)
  );

  int checks = 0, fails = 0, bc = 0, lag = 0;
  bit late_exp = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lt();
    return (bc - lag) & 255;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    bc++;
  endtask

  task automatic do_reset(int l);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; lag = l; lag_cfg = TS_W'(l);
    repeat (3) @(negedge clk);
    chk("R1 reset local_time", int'(local_time), (0 - l) & 255);
    rst_n = 1'b1; bc = 0; late_exp = 0;
    chk("R1 local_time", int'(local_time), (0 - l) & 255);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 slack_valid", int'(slack_valid), 0);
    chk("R1 late_err", int'(late_err), 0);
    chk("R1 retard_slave", int'(retard_slave), 0);
    chk("R1 retard_master", int'(retard_master), 0);
    chk("R1 in_full", int'(in_full), 0);
  endtask

  task automatic single(int s, string tag);
    int ts, d, bdat;
    ts = (lt() + s) & 255;
    bdat = (s * 7 + lag) & 255;
    in_valid = 1'b1; in_ts = TS_W'(ts); in_data = PAY_W'(bdat);
    tick();
    in_valid = 1'b0;
    if (s <= 0) late_exp = 1;
    chk({tag, " R5 slack_valid"}, int'(slack_valid), 1);
    chk({tag, " R5 slack_val"}, int'($signed(slack_val)), s);
    chk({tag, " R6 retard_slave"}, int'(retard_slave), int'(s < 2));
    chk({tag, " R7 retard_master"}, int'(retard_master), int'(s > 8));
    chk({tag, " R8 late_err"}, int'(late_err), int'(late_exp));
    d = (s >= 1) ? s : 1;
    for (int k = 1; k <= d + 2; k++) begin
      chk({tag, " R3 out_valid"}, int'(out_valid), int'(k == d));
      if (k == d) begin
        chk({tag, " R3 out_data"}, int'(out_data), bdat);
        chk({tag, " R3 out_ts"}, int'(out_ts), ts);
      end
      if (k == 2) begin
        chk({tag, " R5 slack pulse"}, int'(slack_valid), 0);
        chk({tag, " R6 hold"}, int'(retard_slave), int'(s < 2));
      end
      tick();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lags [3] = '{3, 40, 200};
    do_reset(3);
    single(6, "R9 wrap");
    foreach (lags[i]) begin
      do_reset(lags[i]);
      for (int s = 1; s <= 12; s++) single(s, "sweep");
      single(0, "late");
      single(-1, "late");
      single(-3, "late");
    end

    do_reset(10);
    for (int k = 0; k < 10; k++) begin
      if (k < 3) begin
        in_valid = 1'b1; in_ts = TS_W'(lt() + 5); in_data = PAY_W'(8'hA0 + k);
      end else in_valid = 1'b0;
      chk("R4 out_valid", int'(out_valid), int'(k >= 5 && k <= 7));
      if (k >= 5 && k <= 7) chk("R4 order", int'(out_data), 8'hA0 + k - 5);
      tick();
    end
    in_valid = 1'b0;

    do_reset(10);
    for (int k = 0; k < 4; k++) begin
      in_valid = 1'b1; in_ts = TS_W'(lt() + 20); in_data = PAY_W'(8'hB0 + k);
      tick();
    end
    chk("R10 in_full", int'(in_full), 1);
    in_valid = 1'b1; in_ts = TS_W'(lt() + 3); in_data = 8'hEE;
    tick();
    in_valid = 1'b0;
    chk("R10 no slack pulse", int'(slack_valid), 0);
    chk("R10 still full", int'(in_full), 1);
    chk("R10 retard held", int'(retard_master), 1);
    for (int k = 5; k < 30; k++) begin
      chk("R10 out_valid", int'(out_valid), int'(k >= 20 && k <= 23));
      if (out_valid) chk("R10 payload", int'(out_data), 8'hB0 + k - 20);
      tick();
    end
    chk("R10 drained", int'(in_full), 0);
    chk("R11 exclusive", int'(retard_slave && retard_master), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule